// File: doc/BRIEF.md
# CPU Operating State Sequencer

This block keeps track of the operating state of a small processor core and tells the rest of the core what to do in that state. It has four states: reset, exception handling, program execution and program halt. The pipeline may fetch only while the core is executing. The clock generator is asked to stop the core clock only while the core is halted. The exception sequencer gets a one-cycle start pulse each time exception handling is entered.

When reset is released, the core does not start running at once. It always passes through exception handling first, so that the start vector can be fetched. Before the reset state is left, the release is qualified through a short chain of flops. The halt state has only two exits: an interrupt request, or reset. The sequencer does not fetch vectors, prioritise or mask interrupts, generate clocks or decode instructions.

Top module: `cpu_state_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is reset: `state_onehot` = 4'b0001, and `fetch_en`, `halt_gate_req` and `exc_entry` are all 0.
- R2: Reset overrides every other input and every state. A rising edge with `rst` high moves the sequencer from exception, execution or halt back to reset.
- R3: The sequencer leaves reset for exception handling at the third consecutive rising edge that samples `rst` low (SYNC_STAGES = 2 qualifying edges plus one). If `rst` rises again before then, the count starts over.
- R4: In exception handling, `exc_done` high moves the sequencer to program execution at the next edge. Otherwise it stays in exception handling, whatever `irq_req` and `sleep_strobe` do.
- R5: In program execution, `sleep_strobe` high with `irq_req` low moves the sequencer to program halt.
- R6: In program execution or program halt, `irq_req` high moves the sequencer to exception handling.
- R7: In program execution, if `irq_req` and `sleep_strobe` are both high, the sequencer goes to exception handling, not to halt.
- R8: Strobes that do not apply to the current state are ignored. `sleep_strobe` outside execution, `exc_done` outside exception handling, and `irq_req`, `sleep_strobe` and `exc_done` in reset leave the state unchanged.
- R9: `state_onehot` always has exactly one bit set: bit 0 reset, bit 1 exception, bit 2 execution, bit 3 halt. `fetch_en` is 1 only in execution and `halt_gate_req` is 1 only in halt.
- R10: `exc_entry` is 1 for exactly the first cycle of every stay in exception handling, whether entered from reset, execution or halt, and 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset request |
| irq_req | input | 1 | An interrupt source is pending |
| sleep_strobe | input | 1 | Decoder executed the sleep instruction |
| exc_done | input | 1 | Exception sequencer finished |
| state_onehot | output | 4 | Current state, one-hot |
| fetch_en | output | 1 | Instruction fetch allowed |
| halt_gate_req | output | 1 | Request to stop the core clock |
| exc_entry | output | 1 | One-cycle pulse on entry to exception handling |

## Verification
The hardest situations to reach are the halt state with a stray strobe applied to it, and a reset release that is interrupted part way through qualification. The bench builds a known path into each of the four states: reset, then release, then done, then sleep. From each state it applies all eight combinations of the three strobes for one cycle and compares the result with an arithmetic reference. To cover the interrupted release, it pulses reset again in the middle of qualification and counts the edges from the final release.

// File: rtl/cpu_state_pkg.sv
package cpu_state_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_EXC   = 2'd1,
        ST_RUN   = 2'd2,
        ST_HALT  = 2'd3
    } cpu_state_e;

    localparam int NUM_STATES = 4;

    typedef struct packed {
        logic irq;
        logic sleep;
        logic done;
    } cpu_strobes_t;

    function automatic logic [NUM_STATES-1:0] state_to_onehot(input cpu_state_e s);
        logic [NUM_STATES-1:0] v;
        v = '0;
        v[s] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/cpu_rel_sync.sv
module cpu_rel_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    output logic rel_o
);
    logic [SYNC_STAGES-1:0] stage_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[0] <= 1'b0;
                else     stage_q[0] <= 1'b1;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= 1'b0;
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign rel_o = stage_q[SYNC_STAGES-1];

    // R3
    rel_follow_chk: assert property (@(posedge clk) disable iff (rst)
        rel_o |=> rel_o);
endmodule

// File: rtl/cpu_state_next.sv
module cpu_state_next
    import cpu_state_pkg::*;
(
    input  cpu_state_e   cur_i,
    input  logic         rel_i,
    input  cpu_strobes_t stb_i,
    output cpu_state_e   nxt_o
);
    always_comb begin
        nxt_o = cur_i;
        unique case (cur_i)
            ST_RESET: if (rel_i)     nxt_o = ST_EXC;
            ST_EXC:   if (stb_i.done) nxt_o = ST_RUN;
            ST_RUN: begin
                if (stb_i.irq)        nxt_o = ST_EXC;
                else if (stb_i.sleep) nxt_o = ST_HALT;
            end
            ST_HALT:  if (stb_i.irq) nxt_o = ST_EXC;
            default:  nxt_o = ST_RESET;
        endcase
    end
endmodule

// File: rtl/cpu_state_seq.sv
module cpu_state_seq
    import cpu_state_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  irq_req,
    input  logic                  sleep_strobe,
    input  logic                  exc_done,
    output logic [NUM_STATES-1:0] state_onehot,
    output logic                  fetch_en,
    output logic                  halt_gate_req,
    output logic                  exc_entry
);
    cpu_state_e   state_q, state_d;
    cpu_strobes_t stb;
    logic         rel;
    logic         entry_q;

    assign stb = '{irq: irq_req, sleep: sleep_strobe, done: exc_done};

    cpu_rel_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .rel_o(rel)
    );

    cpu_state_next u_next (
        .cur_i(state_q),
        .rel_i(rel),
        .stb_i(stb),
        .nxt_o(state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RESET;
            entry_q <= 1'b0;
        end else begin
            state_q <= state_d;
            entry_q <= (state_d == ST_EXC) && (state_q != ST_EXC);
        end
    end

    assign state_onehot  = state_to_onehot(state_q);
    assign fetch_en      = (state_q == ST_RUN);
    assign halt_gate_req = (state_q == ST_HALT);
    assign exc_entry     = entry_q;

    // R9
    onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(state_onehot) == 1);

    // R9
    excl_enable_chk: assert property (@(posedge clk) disable iff (rst)
        !(fetch_en && halt_gate_req));

    // R3
    hold_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (state_onehot[0] && !rel) |=> state_onehot[0]);

    // R4
    done_run_chk: assert property (@(posedge clk) disable iff (rst)
        (state_onehot[1] && exc_done) |=> fetch_en);

    // R7
    irq_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_en && irq_req && sleep_strobe) |=> (state_onehot[1] && exc_entry));

    // R8
    halt_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (halt_gate_req && !irq_req) |=> halt_gate_req);

    // R10
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        exc_entry |=> !exc_entry);

    // R10
    pulse_in_exc_chk: assert property (@(posedge clk) disable iff (rst)
        exc_entry |-> state_onehot[1]);
endmodule

// File: tb/cpu_state_seq_bench.sv
module cpu_state_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       irq_req = 1'b0;
    logic       sleep_strobe = 1'b0;
    logic       exc_done = 1'b0;
    logic [3:0] state_onehot;
    logic       fetch_en, halt_gate_req, exc_entry;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    cpu_state_seq u_cpu_state_seq (
        .clk(clk), .rst(rst), .irq_req(irq_req), .sleep_strobe(sleep_strobe),
        .exc_done(exc_done), .state_onehot(state_onehot), .fetch_en(fetch_en),
        .halt_gate_req(halt_gate_req), .exc_entry(exc_entry)
    );

    // state codes: 0 reset, 1 exception, 2 execution, 3 halt
    function automatic int ref_next(int s, bit i, bit sl, bit d);
        case (s)
            1: return d ? 2 : 1;
            2: return i ? 1 : (sl ? 3 : 2);
            3: return i ? 1 : 3;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, int exp_s, bit exp_pulse);
        logic [6:0] act, exp;
        act = {state_onehot, fetch_en, halt_gate_req, exc_entry};
        exp = {4'b0001 << exp_s, exp_s == 2, exp_s == 3, exp_pulse};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        irq_req = 0; sleep_strobe = 0; exc_done = 0;
    endtask

    // drive into state s; ends at a negedge with the state reached
    task automatic go_to(int s);
        idle();
        rst = 1; step();
        check("R1", 0, 0);
        if (s == 0) return;
        rst = 0; step(); step(); step();
        check("R3", 1, 1);
        if (s == 1) return;
        exc_done = 1; step(); idle();
        check("R4", 2, 0);
        if (s == 2) return;
        sleep_strobe = 1; step(); idle();
        check("R5", 3, 0);
    endtask

    initial begin
        @(negedge clk);
        step();
        check("R1", 0, 0);

        // near-exhaustive sweep: every state x every strobe combination
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 8; c++) begin
                int e;
                string tag;
                go_to(s);
                rst = 0;
                irq_req = c[2]; sleep_strobe = c[1]; exc_done = c[0];
                e = ref_next(s, c[2], c[1], c[0]);
                if (s == 0) tag = "R8";
                else if (s == 1) tag = c[0] ? "R4" : "R8";
                else if (c[2] && c[1] && s == 2) tag = "R7";
                else if (c[2]) tag = "R6";
                else if (s == 2 && c[1]) tag = "R5";
                else tag = "R8";
                step(); idle();
                check(tag, e, (e == 1) && (s != 1));
                if (e == 1) begin
                    step();
                    check("R10", 1, 0);
                end
            end
        end

        // reset overrides each state, even with strobes active
        for (int s = 1; s < 4; s++) begin
            go_to(s);
            irq_req = 1; sleep_strobe = 1; exc_done = 1; rst = 1;
            step(); idle();
            check("R2", 0, 0);
        end

        // interrupted release restarts qualification
        rst = 1; step();
        rst = 0; step();
        check("R3", 0, 0);
        rst = 1; step();
        rst = 0; step();
        check("R3", 0, 0);
        step();
        check("R3", 0, 0);
        step();
        check("R3", 1, 1);
        step();
        check("R10", 1, 0);

        // full loop: exc -> run -> halt -> exc -> run -> exc
        exc_done = 1; step(); idle(); check("R4", 2, 0);
        sleep_strobe = 1; step(); idle(); check("R5", 3, 0);
        step(); check("R9", 3, 0);
        irq_req = 1; step(); idle(); check("R6", 1, 1);
        exc_done = 1; step(); idle(); check("R4", 2, 0);
        irq_req = 1; step(); idle(); check("R6", 1, 1);

        done_flag = 1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule